// File: doc/BRIEF.md
# PCI Interrupt Swizzle and Router

This block turns PCI interrupt events into request levels for a 16-input interrupt controller. Each event carries the device/function number of the source, the pin it asserts or releases (0 to 3 for pins A to D), and the new level. A slot-dependent swizzle first reduces the source to one of four shared PCI interrupt lines. The block keeps the current level of each line.

Every line has its own route register. The register names the controller input that the line drives, or disables the line when its value is out of range. Each controller input carries the OR of all lines that are high and routed to it. Software moves a line by rewriting its route register.

The controller request vector is registered. It is computed from the state that the clock edge writes, so an event or a route write is visible on the outputs directly after the edge that accepts it.

Top module: `pci_irq_router`

## Requirements
- R1: Reset (rst_ni low, asynchronous) clears every line level and loads every route register with 0x80, which is a disabled route. pic_irq_o therefore reads 0, and it stays 0 after reset even when sources raise all four lines, until a route is written.
- R2: The slot number is src_devfn_i[7:3]. The function bits src_devfn_i[2:0] have no effect on which line an event targets.
- R3: An event from slot 10 targets line 3, whatever its pin.
- R4: An event from slot 11 or slot 12 targets line 0, whatever its pin.
- R5: An event from slots 18 to 21 targets line ((slot - 18) + pin) mod 4.
- R6: An event from any other slot targets the line whose number equals its pin.
- R7: On an accepted event (src_valid_i high at a rising edge), the targeted line takes src_level_i. The line holds that level until the next event that targets it, whichever source sends it.
- R8: A route value of 16 or more disables its line, so the line drives no controller input. Values 0 to 15 select that input, including the boundary value 15.
- R9: pic_irq_o[n] is the OR of the levels of all lines whose route register holds n.
- R10: Events and route writes are applied on the rising edge that samples them, and pic_irq_o shows the result right after that edge. A route write and an event in the same cycle both take effect. pic_irq_o does not change on a cycle with neither.
- R11: A route write (route_we_i high) loads route_data_i into the route register of line route_sel_i. When a high line is moved, its old input drops and its new input rises on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_valid_i | input | 1 | Interrupt event strobe |
| src_devfn_i | input | 8 | Device/function number of the event source |
| src_pin_i | input | 2 | Interrupt pin of the source, 0 to 3 |
| src_level_i | input | 1 | New level of that pin |
| route_we_i | input | 1 | Route register write strobe |
| route_sel_i | input | 2 | Line whose route register is written |
| route_data_i | input | 8 | New route value |
| pic_irq_o | output | 16 | Request level for each interrupt controller input |

## Verification
The bench targets the swizzle boundaries. It covers slots 17 and 22 next to the rotating range, the on-board slots with every pin, and devfn values whose function bits differ. A mis-decoded slot would light the wrong controller input. Two sources share a line with opposite levels: a design that kept a level per source instead of per line would leave the input high. Route values 15, 16 and 0xFF probe the disable threshold. Several lines share one input to catch a last-writer-wins merge in place of an OR. A high line is moved between inputs, and a write coincides with an event, to expose a design that reads stale state or adds a pipeline stage.

// File: rtl/pir_pkg.sv
package pir_pkg;
  localparam int unsigned PIR_LINES     = 4;
  localparam int unsigned PIR_INPUTS    = 16;
  localparam int unsigned PIR_DEVFN_W   = 8;
  localparam int unsigned PIR_FN_W      = 3;
  localparam int unsigned PIR_ROUTE_W   = 8;
  localparam logic [7:0]  PIR_ROUTE_OFF = 8'h80;
  localparam int unsigned PIR_ROT_BASE  = 18;

  typedef enum logic [1:0] {
    PIN_A = 2'd0,
    PIN_B = 2'd1,
    PIN_C = 2'd2,
    PIN_D = 2'd3
  } pir_pin_e;
endpackage

// File: rtl/pir_swizzle.sv
module pir_swizzle #(
  parameter int unsigned DEVFN_W   = pir_pkg::PIR_DEVFN_W,
  parameter int unsigned FN_W      = pir_pkg::PIR_FN_W,
  parameter int unsigned NUM_LINES = pir_pkg::PIR_LINES,
  parameter int unsigned ROT_BASE  = pir_pkg::PIR_ROT_BASE,
  parameter int unsigned NUM_FIX   = 3,
  parameter int unsigned FIX_SLOT [NUM_FIX] = '{10, 11, 12},
  parameter int unsigned FIX_LINE [NUM_FIX] = '{3, 0, 0}
) (
  input  logic [DEVFN_W-1:0]           devfn_i,
  input  logic [$clog2(NUM_LINES)-1:0] pin_i,
  output logic [$clog2(NUM_LINES)-1:0] line_o
);
  localparam int unsigned LINE_W = $clog2(NUM_LINES);
  localparam int unsigned SLOT_W = DEVFN_W - FN_W;
  localparam logic [SLOT_W-1:0] ROT_LO = SLOT_W'(ROT_BASE);
  localparam logic [SLOT_W-1:0] ROT_HI = SLOT_W'(ROT_BASE + NUM_LINES - 1);

  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] rot_off;
  logic              in_rot;
  logic [NUM_FIX-1:0] fix_hit;

  assign slot    = devfn_i[DEVFN_W-1:FN_W];
  assign rot_off = slot - ROT_LO;
  assign in_rot  = (slot >= ROT_LO) && (slot <= ROT_HI);

  for (genvar f = 0; f < NUM_FIX; f++) begin : g_fix
    assign fix_hit[f] = (slot == SLOT_W'(FIX_SLOT[f]));
  end

  always_comb begin
    line_o = pin_i;
    if (in_rot) line_o = rot_off[LINE_W-1:0] + pin_i;
    for (int f = NUM_FIX - 1; f >= 0; f--) begin
      if (fix_hit[f]) line_o = LINE_W'(FIX_LINE[f]);
    end
  end
endmodule

// File: rtl/pir_line_state.sv
module pir_line_state #(
  parameter int unsigned NUM_LINES = pir_pkg::PIR_LINES,
  parameter int unsigned ROUTE_W   = pir_pkg::PIR_ROUTE_W,
  parameter logic [ROUTE_W-1:0] ROUTE_RST = ROUTE_W'(pir_pkg::PIR_ROUTE_OFF)
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                upd_valid_i,
  input  logic [$clog2(NUM_LINES)-1:0]        upd_line_i,
  input  logic                                upd_level_i,
  input  logic                                route_we_i,
  input  logic [$clog2(NUM_LINES)-1:0]        route_sel_i,
  input  logic [ROUTE_W-1:0]                  route_data_i,
  output logic [NUM_LINES-1:0]                lvl_q_o,
  output logic [NUM_LINES-1:0]                lvl_d_o,
  output logic [NUM_LINES-1:0][ROUTE_W-1:0]   route_q_o,
  output logic [NUM_LINES-1:0][ROUTE_W-1:0]   route_d_o
);
  localparam int unsigned LINE_W = $clog2(NUM_LINES);

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    always_comb begin
      lvl_d_o[l] = lvl_q_o[l];
      if (upd_valid_i && (upd_line_i == LINE_W'(l))) lvl_d_o[l] = upd_level_i;
    end

    always_comb begin
      route_d_o[l] = route_q_o[l];
      if (route_we_i && (route_sel_i == LINE_W'(l))) route_d_o[l] = route_data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lvl_q_o[l]   <= 1'b0;
        route_q_o[l] <= ROUTE_RST;
      end else begin
        lvl_q_o[l]   <= lvl_d_o[l];
        route_q_o[l] <= route_d_o[l];
      end
    end
  end
endmodule

// File: rtl/pir_fanin.sv
module pir_fanin #(
  parameter int unsigned NUM_LINES  = pir_pkg::PIR_LINES,
  parameter int unsigned NUM_INPUTS = pir_pkg::PIR_INPUTS,
  parameter int unsigned ROUTE_W    = pir_pkg::PIR_ROUTE_W
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_LINES-1:0]              lvl_i,
  input  logic [NUM_LINES-1:0][ROUTE_W-1:0] route_i,
  output logic [NUM_INPUTS-1:0]             irq_o
);
  logic [NUM_INPUTS-1:0] irq_d;

  // Out-of-range route values match no input and so disable the line.
  for (genvar n = 0; n < NUM_INPUTS; n++) begin : g_in
    logic [NUM_LINES-1:0] hit;
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_ln
      assign hit[l] = lvl_i[l] && (route_i[l] == ROUTE_W'(n));
    end
    assign irq_d[n] = |hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= '0;
    else         irq_o <= irq_d;
  end
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router #(
  parameter int unsigned NUM_LINES  = pir_pkg::PIR_LINES,
  parameter int unsigned NUM_INPUTS = pir_pkg::PIR_INPUTS,
  parameter int unsigned DEVFN_W    = pir_pkg::PIR_DEVFN_W,
  parameter int unsigned ROUTE_W    = pir_pkg::PIR_ROUTE_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         src_valid_i,
  input  logic [DEVFN_W-1:0]           src_devfn_i,
  input  logic [$clog2(NUM_LINES)-1:0] src_pin_i,
  input  logic                         src_level_i,
  input  logic                         route_we_i,
  input  logic [$clog2(NUM_LINES)-1:0] route_sel_i,
  input  logic [ROUTE_W-1:0]           route_data_i,
  output logic [NUM_INPUTS-1:0]        pic_irq_o
);
  localparam int unsigned LINE_W = $clog2(NUM_LINES);

  logic [LINE_W-1:0]                 tgt_line;
  logic [NUM_LINES-1:0]              line_lvl_q;
  logic [NUM_LINES-1:0]              line_lvl_d;
  logic [NUM_LINES-1:0][ROUTE_W-1:0] route_q;
  logic [NUM_LINES-1:0][ROUTE_W-1:0] route_d;

  pir_swizzle #(
    .DEVFN_W   (DEVFN_W),
    .NUM_LINES (NUM_LINES)
  ) u_swizzle (
    .devfn_i (src_devfn_i),
    .pin_i   (src_pin_i),
    .line_o  (tgt_line)
  );

  pir_line_state #(
    .NUM_LINES (NUM_LINES),
    .ROUTE_W   (ROUTE_W)
  ) u_state (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .upd_valid_i  (src_valid_i),
    .upd_line_i   (tgt_line),
    .upd_level_i  (src_level_i),
    .route_we_i   (route_we_i),
    .route_sel_i  (route_sel_i),
    .route_data_i (route_data_i),
    .lvl_q_o      (line_lvl_q),
    .lvl_d_o      (line_lvl_d),
    .route_q_o    (route_q),
    .route_d_o    (route_d)
  );

  pir_fanin #(
    .NUM_LINES  (NUM_LINES),
    .NUM_INPUTS (NUM_INPUTS),
    .ROUTE_W    (ROUTE_W)
  ) u_fanin (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_i   (line_lvl_d),
    .route_i (route_d),
    .irq_o   (pic_irq_o)
  );
endmodule

// File: rtl/pir_checker.sv
module pir_checker #(
  parameter int unsigned NUM_LINES  = 4,
  parameter int unsigned NUM_INPUTS = 16,
  parameter int unsigned DEVFN_W    = 8,
  parameter int unsigned ROUTE_W    = 8
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic                              src_valid_i,
  input logic [DEVFN_W-1:0]                src_devfn_i,
  input logic                              src_level_i,
  input logic                              route_we_i,
  input logic [$clog2(NUM_LINES)-1:0]      route_sel_i,
  input logic [ROUTE_W-1:0]                route_data_i,
  input logic [NUM_LINES-1:0]              line_lvl_q,
  input logic [NUM_LINES-1:0][ROUTE_W-1:0] route_q,
  input logic [NUM_INPUTS-1:0]             pic_irq_o
);
  localparam int unsigned SLOT_W = DEVFN_W - 3;

  logic all_off;
  always_comb begin
    all_off = 1'b1;
    for (int l = 0; l < NUM_LINES; l++) begin
      if (route_q[l] < ROUTE_W'(NUM_INPUTS)) all_off = 1'b0;
    end
  end

  assert_all_off_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_off |-> (pic_irq_o == '0));

  assert_or_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(pic_irq_o) <= $countones(line_lvl_q));

  assert_level_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !src_valid_i |=> $stable(line_lvl_q));

  assert_route_load_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    route_we_i |=> (route_q[$past(route_sel_i)] == $past(route_data_i)));

  assert_idle_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!src_valid_i && !route_we_i) |=> $stable(pic_irq_o));

  assert_slot10_line3_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_valid_i && (src_devfn_i[DEVFN_W-1:3] == SLOT_W'(10)))
      |=> (line_lvl_q[3] == $past(src_level_i)));
endmodule

bind pci_irq_router pir_checker #(
  .NUM_LINES  (NUM_LINES),
  .NUM_INPUTS (NUM_INPUTS),
  .DEVFN_W    (DEVFN_W),
  .ROUTE_W    (ROUTE_W)
) u_pir_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .src_valid_i  (src_valid_i),
  .src_devfn_i  (src_devfn_i),
  .src_level_i  (src_level_i),
  .route_we_i   (route_we_i),
  .route_sel_i  (route_sel_i),
  .route_data_i (route_data_i),
  .line_lvl_q   (line_lvl_q),
  .route_q      (route_q),
  .pic_irq_o    (pic_irq_o)
);

// File: tb/pci_irq_router_tb_top.sv
`timescale 1ns/1ps
module pci_irq_router_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        src_valid_i = 1'b0;
  logic [7:0]  src_devfn_i = '0;
  logic [1:0]  src_pin_i = '0;
  logic        src_level_i = 1'b0;
  logic        route_we_i = 1'b0;
  logic [1:0]  route_sel_i = '0;
  logic [7:0]  route_data_i = '0;
  logic [15:0] pic_irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_lvl [4];
  int m_route [4];

  always #2.5 clk_i = ~clk_i;

  pci_irq_router dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .src_valid_i  (src_valid_i),
    .src_devfn_i  (src_devfn_i),
    .src_pin_i    (src_pin_i),
    .src_level_i  (src_level_i),
    .route_we_i   (route_we_i),
    .route_sel_i  (route_sel_i),
    .route_data_i (route_data_i),
    .pic_irq_o    (pic_irq_o)
  );

  function automatic int ref_line(int devfn, int pin);
    int s = devfn / 8;
    if (s == 10) return 3;
    if (s == 11 || s == 12) return 0;
    if (s >= 18 && s <= 21) return (s - 18 + pin) % 4;
    return pin;
  endfunction

  function automatic logic [15:0] ref_out();
    logic [15:0] v = '0;
    for (int l = 0; l < 4; l++) begin
      if (m_lvl[l] != 0 && m_route[l] < 16) v[m_route[l]] = 1'b1;
    end
    return v;
  endfunction

  task automatic chk(string tag);
    logic [15:0] exp = ref_out();
    checks++;
    if (pic_irq_o !== exp) begin
      errors++;
      $display("FAIL %s: pic_irq_o=%h expected %h", tag, pic_irq_o, exp);
    end
  endtask

  // One clock: inputs were set after the last falling edge.
  task automatic cyc(string tag);
    @(posedge clk_i);
    if (route_we_i) m_route[route_sel_i] = int'(route_data_i);
    if (src_valid_i) m_lvl[ref_line(int'(src_devfn_i), int'(src_pin_i))] = int'(src_level_i);
    @(negedge clk_i);
    chk(tag);
    src_valid_i = 1'b0;
    route_we_i  = 1'b0;
  endtask

  task automatic ev(int slot, int fn, int pin, bit lvl, string tag);
    src_valid_i = 1'b1;
    src_devfn_i = 8'(slot * 8 + fn);
    src_pin_i   = 2'(pin);
    src_level_i = lvl;
    cyc(tag);
  endtask

  task automatic rt(int line, int val, string tag);
    route_we_i   = 1'b1;
    route_sel_i  = 2'(line);
    route_data_i = 8'(val);
    cyc(tag);
  endtask

  task automatic clear_lines();
    for (int p = 0; p < 4; p++) ev(0, 0, p, 1'b0, "R6");
  endtask

  initial begin
    for (int l = 0; l < 4; l++) begin
      m_lvl[l] = 0;
      m_route[l] = 8'h80;
    end
    repeat (3) @(negedge clk_i);
    chk("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1");

    // R1: default routes are disabled
    for (int p = 0; p < 4; p++) ev(0, 0, p, 1'b1, "R1");
    clear_lines();

    for (int l = 0; l < 4; l++) rt(l, 4 + l, "R11");

    // R3: slot 10 always line 3
    for (int p = 0; p < 4; p++) begin
      ev(10, 0, p, 1'b1, "R3");
      ev(10, 0, p, 1'b0, "R3");
    end
    // R4: slots 11, 12 always line 0
    for (int p = 0; p < 4; p++) begin
      ev(11, 0, p, 1'b1, "R4");
      ev(11, 0, p, 1'b0, "R4");
      ev(12, 0, p, 1'b1, "R4");
      ev(12, 0, p, 1'b0, "R4");
    end
    // R5: rotating slots
    for (int s = 18; s <= 21; s++) begin
      for (int p = 0; p < 4; p++) begin
        ev(s, 0, p, 1'b1, "R5");
        ev(s, 0, p, 1'b0, "R5");
      end
    end
    // R6: pass-through slots, including neighbours of the ranges
    begin
      int pass_slots [6] = '{0, 5, 9, 13, 17, 22};
      foreach (pass_slots[i]) begin
        for (int p = 0; p < 4; p++) begin
          ev(pass_slots[i], 0, p, 1'b1, "R6");
          ev(pass_slots[i], 0, p, 1'b0, "R6");
        end
      end
    end
    // R2: function bits ignored
    for (int f = 0; f < 8; f++) begin
      ev(10, f, 1, 1'b1, "R2");
      ev(19, f, 2, 1'b1, "R2");
      clear_lines();
    end

    // R7: shared line, last writer wins
    ev(5, 0, 1, 1'b1, "R7");
    ev(19, 0, 0, 1'b0, "R7");
    ev(19, 0, 0, 1'b1, "R7");
    repeat (3) cyc("R7");
    ev(5, 0, 1, 1'b0, "R7");
    clear_lines();

    // R8: disable threshold
    for (int p = 0; p < 4; p++) ev(0, 0, p, 1'b1, "R8");
    rt(2, 15, "R8");
    rt(2, 16, "R8");
    rt(2, 255, "R8");
    rt(2, 0, "R8");
    for (int l = 0; l < 4; l++) rt(l, 8'h80, "R8");
    cyc("R8");

    // R9: several lines on one input
    for (int l = 0; l < 4; l++) rt(l, 9, "R9");
    ev(0, 0, 0, 1'b0, "R9");
    ev(0, 0, 1, 1'b0, "R9");
    ev(0, 0, 2, 1'b0, "R9");
    ev(0, 0, 3, 1'b0, "R9");
    ev(0, 0, 2, 1'b1, "R9");

    // R11: move a high line
    rt(2, 3, "R11");
    rt(2, 12, "R11");

    // R10: write and event in the same cycle, then idle cycles
    route_we_i = 1'b1; route_sel_i = 2'd1; route_data_i = 8'd14;
    src_valid_i = 1'b1; src_devfn_i = 8'd0; src_pin_i = 2'd1; src_level_i = 1'b1;
    cyc("R10");
    repeat (4) cyc("R10");

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(1, 0) == 1) begin
        route_we_i   = 1'b1;
        route_sel_i  = 2'($urandom_range(3, 0));
        route_data_i = ($urandom_range(3, 0) == 0) ? 8'($urandom_range(255, 16))
                                                   : 8'($urandom_range(15, 0));
      end
      if ($urandom_range(2, 0) != 0) begin
        src_valid_i = 1'b1;
        src_devfn_i = 8'($urandom_range(255, 0));
        src_pin_i   = 2'($urandom_range(3, 0));
        src_level_i = 1'($urandom_range(1, 0));
      end
      cyc("R9");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule